// File: doc/BRIEF.md
# Mixed-Weight Parallel Counter Set

This block gathers four small combinational counters for building compressor trees. Each counter takes a handful of bits, counts the ones, and returns the total as a binary number. Two of the counters take bits of a single weight. The other two also take a second group of bits that each count double. One mixed-weight counter can therefore do the work of several full adders that straddle two adjacent columns of a partial-product or multi-operand array.

A shape is written (k1,k0;n). It takes k0 bits of weight one and k1 bits of weight two, and gives an n-bit result. The set provides (0,5;3), (0,6;3), (3,4;4) and (3,5;4). The single-column counters are built from full adders and half adders, and their last stage is a two-column ripple. The block also includes a separator cell. When two counters are chained along one carry path, this cell stops any arithmetic from crossing the boundary between them: it adds a value to itself plus the incoming carry. Every path is purely combinational and has no clock or reset.

Top module: `gpc_lib_top`

## Requirements
- R1: The (0,5;3) output `c053_sum_o` equals the number of ones in the 5-bit input `c053_w1_i`.
- R2: The (0,6;3) output `c063_sum_o` equals the number of ones in the 6-bit input `c063_w1_i`.
- R3: The (3,4;4) output `c344_sum_o` equals the ones in the 4-bit `c344_w1_i` plus two times the ones in the 3-bit `c344_w2_i`.
- R4: The (3,5;4) output `c354_sum_o` equals the ones in the 5-bit `c354_w1_i` plus two times the ones in the 3-bit `c354_w2_i`.
- R5: No output ever exceeds the maximum for its shape: 5 for (0,5;3), 6 for (0,6;3), 10 for (3,4;4) and 11 for (3,5;4).
- R6: The separator sum output `sep_sum_o` always equals the incoming carry `sep_cin_i`, whatever the value input.
- R7: The separator carry output `sep_cout_o` always equals the value input `sep_val_i`, whatever the incoming carry.
- R8: Bit 0 of each single-column counter output equals the XOR of all of that counter's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| c053_w1_i | input | 5 | Weight-one bits of the (0,5;3) counter |
| c053_sum_o | output | 3 | Count for (0,5;3) |
| c063_w1_i | input | 6 | Weight-one bits of the (0,6;3) counter |
| c063_sum_o | output | 3 | Count for (0,6;3) |
| c344_w1_i | input | 4 | Weight-one bits of the (3,4;4) counter |
| c344_w2_i | input | 3 | Weight-two bits of the (3,4;4) counter |
| c344_sum_o | output | 4 | Weighted count for (3,4;4) |
| c354_w1_i | input | 5 | Weight-one bits of the (3,5;4) counter |
| c354_w2_i | input | 3 | Weight-two bits of the (3,5;4) counter |
| c354_sum_o | output | 4 | Weighted count for (3,5;4) |
| sep_val_i | input | 1 | Value fed twice into the separator cell |
| sep_cin_i | input | 1 | Carry arriving at the separator cell |
| sep_sum_o | output | 1 | Separator sum, equal to the incoming carry |
| sep_cout_o | output | 1 | Separator carry out, equal to the value |

## Verification
Every input vector of every counter is applied. This separates a wrong column weight, a dropped or doubled input and a broken carry between columns, because each of these errors changes the result for at least one vector. The all-ones vectors show the full-scale values 5, 6, 10 and 11 and whether the top bit is reached. Vectors with a single one in the weight-two group show that those bits count double and not single. Random vectors applied to all counters at once check that the counters do not interfere with each other. All four separator input pairs are applied, which tells apart a cell that passes the carry straight through from one that adds across the boundary.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int C053_W1 = 5;
  localparam int C063_W1 = 6;
  localparam int C344_W1 = 4;
  localparam int C344_W2 = 3;
  localparam int C354_W1 = 5;
  localparam int C354_W2 = 3;
  localparam int MAX_W1  = 6;  // widest single-column shape built from adder cells

  function automatic int shape_max(input int k0, input int k1);
    return k0 + 2 * k1;
  endfunction

  function automatic int shape_width(input int k0, input int k1);
    return $clog2(shape_max(k0, k1) + 1);
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign {co_o, s_o} = {1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i};
endmodule

// File: rtl/ha_cell.sv
module ha_cell (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic co_o
);
  assign {co_o, s_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/gpc_sep_cell.sv
module gpc_sep_cell (
  input  logic val_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  // cin + 2*val: the sum bit carries cin, the carry bit carries val
  assign {cout_o, sum_o} = {1'b0, val_i} + {1'b0, val_i} + {1'b0, cin_i};

  always_comb begin
    p_sep_sum_r6: assert (sum_o == cin_i) else $error("separator sum mismatch");
    p_sep_cout_r7: assert (cout_o == val_i) else $error("separator carry mismatch");
  end
endmodule

// File: rtl/gpc_w1_count.sv
module gpc_w1_count #(
  parameter int K  = 6,
  localparam int NW = $clog2(K + 1)
) (
  input  logic [K-1:0]  bits_i,
  output logic [NW-1:0] sum_o
);
  import gpc_pkg::*;

  logic [MAX_W1-1:0] a;
  logic s0, c0, s1, c1, k0, z1, z2;

  generate
    if (K == MAX_W1) begin : g_full
      assign a = bits_i;
    end else begin : g_pad
      assign a = {{(MAX_W1 - K){1'b0}}, bits_i};
    end
  endgenerate

  fa_cell u_fa_lo (.a_i(a[1]), .b_i(a[2]), .c_i(a[3]), .s_o(s0), .co_o(c0));
  ha_cell u_ha_hi (.a_i(a[4]), .b_i(a[5]), .s_o(s1), .co_o(c1));
  // two-column final adder
  fa_cell u_col0  (.a_i(s0), .b_i(s1), .c_i(a[0]), .s_o(sum_o[0]), .co_o(k0));
  fa_cell u_col1  (.a_i(c0), .b_i(c1), .c_i(k0), .s_o(z1), .co_o(z2));

  assign sum_o[NW-1:1] = {z2, z1};

  always_comb begin
    // R1 / R2: structural count agrees with a population count
    p_count_match_r1: assert (int'(sum_o) == $countones(bits_i)) else $error("w1 count mismatch");
    p_no_overflow_r5: assert (int'(sum_o) <= K) else $error("w1 count overflow");
    p_parity_r8: assert (sum_o[0] == ^bits_i) else $error("w1 parity mismatch");
  end
endmodule

// File: rtl/gpc_w21_count.sv
module gpc_w21_count #(
  parameter int K0 = 5,
  parameter int K1 = 3,
  localparam int NW = gpc_pkg::shape_width(K0, K1)
) (
  input  logic [K0-1:0] w1_i,
  input  logic [K1-1:0] w2_i,
  output logic [NW-1:0] sum_o
);
  logic [NW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < K0; i++) acc = acc + NW'(w1_i[i]);
    for (int j = 0; j < K1; j++) acc = acc + NW'({w2_i[j], 1'b0});
  end

  assign sum_o = acc;

  always_comb begin
    // R3 / R4: weighted count
    p_weighted_r3: assert (int'(sum_o) == $countones(w1_i) + 2 * $countones(w2_i))
      else $error("weighted count mismatch");
    p_no_overflow_r5: assert (int'(sum_o) <= gpc_pkg::shape_max(K0, K1))
      else $error("weighted count overflow");
  end
endmodule

// File: rtl/gpc_lib_top.sv
module gpc_lib_top (
  input  logic [4:0] c053_w1_i,
  output logic [2:0] c053_sum_o,
  input  logic [5:0] c063_w1_i,
  output logic [2:0] c063_sum_o,
  input  logic [3:0] c344_w1_i,
  input  logic [2:0] c344_w2_i,
  output logic [3:0] c344_sum_o,
  input  logic [4:0] c354_w1_i,
  input  logic [2:0] c354_w2_i,
  output logic [3:0] c354_sum_o,
  input  logic       sep_val_i,
  input  logic       sep_cin_i,
  output logic       sep_sum_o,
  output logic       sep_cout_o
);
  import gpc_pkg::*;

  gpc_w1_count #(.K(C053_W1)) u_c053 (.bits_i(c053_w1_i), .sum_o(c053_sum_o));
  gpc_w1_count #(.K(C063_W1)) u_c063 (.bits_i(c063_w1_i), .sum_o(c063_sum_o));

  gpc_w21_count #(.K0(C344_W1), .K1(C344_W2)) u_c344 (
    .w1_i(c344_w1_i), .w2_i(c344_w2_i), .sum_o(c344_sum_o));
  gpc_w21_count #(.K0(C354_W1), .K1(C354_W2)) u_c354 (
    .w1_i(c354_w1_i), .w2_i(c354_w2_i), .sum_o(c354_sum_o));

  gpc_sep_cell u_sep (
    .val_i(sep_val_i), .cin_i(sep_cin_i), .sum_o(sep_sum_o), .cout_o(sep_cout_o));
endmodule

// File: tb/gpc_lib_top_tb_top.sv
module gpc_lib_top_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [4:0] c053_w1;  logic [2:0] c053_sum;
  logic [5:0] c063_w1;  logic [2:0] c063_sum;
  logic [3:0] c344_w1;  logic [2:0] c344_w2;  logic [3:0] c344_sum;
  logic [4:0] c354_w1;  logic [2:0] c354_w2;  logic [3:0] c354_sum;
  logic sep_val, sep_cin, sep_sum, sep_cout;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  gpc_lib_top dut_i (
    .c053_w1_i(c053_w1), .c053_sum_o(c053_sum),
    .c063_w1_i(c063_w1), .c063_sum_o(c063_sum),
    .c344_w1_i(c344_w1), .c344_w2_i(c344_w2), .c344_sum_o(c344_sum),
    .c354_w1_i(c354_w1), .c354_w2_i(c354_w2), .c354_sum_o(c354_sum),
    .sep_val_i(sep_val), .sep_cin_i(sep_cin), .sep_sum_o(sep_sum), .sep_cout_o(sep_cout)
  );

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int xor_all(input logic [7:0] v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= int'(v[i]);
    return p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_le(input string req, input int act, input int lim);
    n_run++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected <= %0d", req, act, lim);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_all();
    check("R1", int'(c053_sum), ones({3'b0, c053_w1}));
    check("R2", int'(c063_sum), ones({2'b0, c063_w1}));
    check("R3", int'(c344_sum), ones({4'b0, c344_w1}) + 2 * ones({5'b0, c344_w2}));
    check("R4", int'(c354_sum), ones({3'b0, c354_w1}) + 2 * ones({5'b0, c354_w2}));
    check_le("R5", int'(c053_sum), 5);
    check_le("R5", int'(c063_sum), 6);
    check_le("R5", int'(c344_sum), 10);
    check_le("R5", int'(c354_sum), 11);
    check("R8", int'(c053_sum[0]), xor_all({3'b0, c053_w1}));
    check("R8", int'(c063_sum[0]), xor_all({2'b0, c063_w1}));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1d5);
    c053_w1 = '0; c063_w1 = '0; c344_w1 = '0; c344_w2 = '0;
    c354_w1 = '0; c354_w2 = '0; sep_val = 1'b0; sep_cin = 1'b0;

    // all-zero state
    settle();
    check("R1", int'(c053_sum), 0);
    check("R3", int'(c344_sum), 0);

    // directed full-scale and single weight-two bit
    c053_w1 = '1; c063_w1 = '1; c344_w1 = '1; c344_w2 = '1; c354_w1 = '1; c354_w2 = '1;
    settle();
    check("R1", int'(c053_sum), 5);
    check("R2", int'(c063_sum), 6);
    check("R3", int'(c344_sum), 10);
    check("R4", int'(c354_sum), 11);
    c344_w1 = '0; c344_w2 = 3'b010; c354_w1 = '0; c354_w2 = 3'b100;
    settle();
    check("R3", int'(c344_sum), 2);
    check("R4", int'(c354_sum), 2);

    // exhaustive sweeps
    for (int v = 0; v < 32; v++) begin
      c053_w1 = 5'(v); settle(); check_all();
    end
    for (int v = 0; v < 64; v++) begin
      c063_w1 = 6'(v); settle(); check_all();
    end
    for (int v = 0; v < 128; v++) begin
      {c344_w2, c344_w1} = 7'(v); settle(); check_all();
    end
    for (int v = 0; v < 256; v++) begin
      {c354_w2, c354_w1} = 8'(v); settle(); check_all();
    end

    // separator: all four input pairs
    for (int v = 0; v < 4; v++) begin
      {sep_val, sep_cin} = 2'(v);
      settle();
      check("R6", int'(sep_sum), v & 1);
      check("R7", int'(sep_cout), v >> 1);
    end

    // random concurrent stimulus
    for (int n = 0; n < 300; n++) begin
      c053_w1 = 5'($urandom); c063_w1 = 6'($urandom);
      c344_w1 = 4'($urandom); c344_w2 = 3'($urandom);
      c354_w1 = 5'($urandom); c354_w2 = 3'($urandom);
      sep_val = 1'($urandom); sep_cin = 1'($urandom);
      settle();
      check_all();
      check("R6", int'(sep_sum), int'(sep_cin));
      check("R7", int'(sep_cout), int'(sep_val));
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule